// File: doc/BRIEF.md
# Flag-Conditioned Delayed Branch Sequencer

This block is the program-counter sequencer of a simple fetch stage. It produces the address of the instruction that issues in each cycle, together with a bit that says whether that slot really issues. A decoded branch request carries a 5-bit condition code, a target address, a delayed-mode flag and a loop-abort flag. The block resolves the condition against a register of stored status flags that an earlier compare or arithmetic step has written. It does not look at register operands.

Every accepted branch opens a window of two slots. In delayed mode the two instructions that follow the branch issue normally, whether or not the branch is taken. In plain mode the two slots become bubbles: the fetch address holds and the issue bit drops, exactly as if two no-ops had been placed after the branch. At the end of the window, fetch either moves to the target or carries on in sequence. A one-cycle taken pulse marks the redirect. A loop-exit pulse comes with it when the branch was also flagged as a loop abort. A stall input freezes the whole sequencer, pending redirect included.

Top module: `branch_seq`

## Requirements
- R1: While reset is active and in the first cycle after it is released, `fetch_addr` is 0 and `taken` and `loop_exit` are 0. No slot window is pending, so that first cycle issues.
- R2: With no branch pending and `stall` low, `issue_valid` is 1 and `fetch_addr` rises by one per cycle.
- R3: Bits [3:0] of `br_cond` select the base condition. The flag register bit positions are 0 zero, 1 negative, 2 carry, 3 ALU overflow, 4 multiplier overflow, 5 multiplier sign, 6 shifter overflow and 7 shifter zero. The base codes are 0 zero, 1 negative, 2 negative-or-zero, 3 carry, 4 ALU overflow, 5 multiplier overflow, 6 multiplier sign, 7 shifter overflow, 8 shifter zero and 9 always.
- R4: Bit 4 of `br_cond` inverts the base condition. The code 9 with the invert bit set is never taken, and so are base codes 10 to 15 in either polarity.
- R5: A branch is accepted when `br_valid` is 1 in an unstalled cycle in which `fetch_addr` is A and no window is pending. If `br_delayed` is 1, the next two unstalled cycles issue addresses A+1 and A+2, whatever the condition. The cycle after them shows the target if the branch is taken and A+3 if it is not.
- R6: If `br_delayed` is 0, the next two unstalled cycles show A+1 with `issue_valid` 0. The cycle after them issues the target if the branch is taken and A+1 if it is not.
- R7: The condition is evaluated on `flags` as they stand in the accepting cycle. Changes to `flags` during the window have no effect on that branch.
- R8: A cycle with `stall` high has `issue_valid` 0 and leaves `fetch_addr` and the slot window unchanged in the following cycle. The pending redirect still happens once the stall ends.
- R9: `taken` is 1 for exactly the one cycle in which `fetch_addr` first shows the target of a taken branch. `loop_exit` is 1 in that same cycle if `br_abort` was set on the branch, and this works in delayed mode as well.
- R10: A `br_valid` that arrives while a window is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes the sequencer for this cycle |
| br_valid | input | 1 | Branch request in decode this cycle |
| br_cond | input | 5 | Condition: [3:0] base selector, [4] invert |
| br_target | input | AW | Branch target address |
| br_delayed | input | 1 | 1: the two following slots issue; 0: they are bubbles |
| br_abort | input | 1 | The branch leaves a hardware loop |
| flags | input | 8 | Stored status flags |
| fetch_addr | output | AW | Address of the current slot |
| issue_valid | output | 1 | The current slot issues |
| taken | output | 1 | First cycle at a taken branch's target |
| loop_exit | output | 1 | Same as taken, for a branch flagged as a loop abort |

## Verification
The assertions check on every cycle that a stall holds the address and blocks issue, and that the slot after an accepted branch is a bubble in plain mode and issues in delayed mode. They also check that the reserved inverted-always code never arms a redirect, and that a loop exit never occurs without a taken pulse. The bench scenarios are needed for the rest: the full decode of all 32 condition codes against several flag patterns, the addresses that appear at the end of each window, flag changes during the window having no effect on the branch, requests during the window being ignored, and a redirect that survives a stall in the middle of the window.

// File: rtl/branch_seq.sv
module branch_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          br_valid,
  input  logic [4:0]    br_cond,
  input  logic [AW-1:0] br_target,
  input  logic          br_delayed,
  input  logic          br_abort,
  input  logic [7:0]    flags,
  output logic [AW-1:0] fetch_addr,
  output logic          issue_valid,
  output logic          taken,
  output logic          loop_exit
);
  localparam logic [3:0] ALWAYS = 4'd9;

  logic [AW-1:0] pc, tgt_q;
  logic [1:0]    slots;
  logic          bub_q, tk_q, ab_q, taken_q, exit_q;
  logic          base_hit, cond_met, accept;

  always_comb begin
    case (br_cond[3:0])
      4'd0:    base_hit = flags[0];
      4'd1:    base_hit = flags[1];
      4'd2:    base_hit = flags[1] | flags[0];
      4'd3:    base_hit = flags[2];
      4'd4:    base_hit = flags[3];
      4'd5:    base_hit = flags[4];
      4'd6:    base_hit = flags[5];
      4'd7:    base_hit = flags[6];
      4'd8:    base_hit = flags[7];
      default: base_hit = 1'b0;
    endcase
  end

  assign cond_met = (br_cond[3:0] == ALWAYS) ? ~br_cond[4] :
                    (br_cond[3:0] > ALWAYS)  ? 1'b0 : (base_hit ^ br_cond[4]);
  assign accept      = br_valid && !stall && slots == 2'd0;
  assign fetch_addr  = pc;
  assign issue_valid = !stall && !(slots != 2'd0 && bub_q);
  assign taken       = taken_q;
  assign loop_exit   = exit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      tgt_q   <= '0;
      slots   <= 2'd0;
      bub_q   <= 1'b0;
      tk_q    <= 1'b0;
      ab_q    <= 1'b0;
      taken_q <= 1'b0;
      exit_q  <= 1'b0;
    end else begin
      taken_q <= !stall && slots == 2'd1 && tk_q;
      exit_q  <= !stall && slots == 2'd1 && tk_q && ab_q;
      if (!stall) begin
        case (slots)
          2'd0: begin
            pc <= pc + 1'b1;
            if (accept) begin
              slots <= 2'd2;
              tgt_q <= br_target;
              bub_q <= ~br_delayed;
              tk_q  <= cond_met;
              ab_q  <= br_abort;
            end
          end
          2'd2: begin
            slots <= 2'd1;
            if (!bub_q) pc <= pc + 1'b1;
          end
          default: begin
            slots <= 2'd0;
            if (tk_q)        pc <= tgt_q;
            else if (!bub_q) pc <= pc + 1'b1;
          end
        endcase
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> fetch_addr == $past(fetch_addr));
  // R8
  stall_noissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !issue_valid);
  // R6
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !br_delayed) |=> !issue_valid);
  // R5
  delay_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && br_delayed) |=> (issue_valid || stall));
  // R4
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && br_cond == 5'b11001) |=> !tk_q);
  // R9
  exit_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_exit |-> taken);
endmodule

// File: tb/sim_branch_seq.sv
module sim_branch_seq;
  localparam int AW = 16;
  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0, br_valid = 1'b0;
  logic br_delayed = 1'b0, br_abort = 1'b0;
  logic [4:0] br_cond = '0;
  logic [AW-1:0] br_target = '0;
  logic [7:0] flags = '0;
  logic [AW-1:0] fetch_addr;
  logic issue_valid, taken, loop_exit;

  branch_seq #(.AW(AW)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  logic [AW+2:0] exp_q[$];
  string tag_q[$];

  logic [AW-1:0] m_pc = '0, m_tgt = '0;
  int m_cnt = 0;
  logic m_bub = 0, m_tk = 0, m_ab = 0, m_tp = 0, m_xp = 0;

  function automatic logic ref_cond(input logic [4:0] c, input logic [7:0] f);
    logic r;
    if (c[3:0] == 4'd9) return !c[4];
    if (c[3:0] > 4'd9) return 1'b0;
    case (c[3:0])
      4'd0: r = f[0]; 4'd1: r = f[1]; 4'd2: r = f[0] || f[1];
      4'd3: r = f[2]; 4'd4: r = f[3]; 4'd5: r = f[4];
      4'd6: r = f[5]; 4'd7: r = f[6]; default: r = f[7];
    endcase
    return c[4] ? !r : r;
  endfunction

  task automatic model_push(input string tag);
    logic ntp;
    exp_q.push_back({m_pc, !stall && !(m_cnt != 0 && m_bub), m_tp, m_xp});
    tag_q.push_back(tag);
    ntp = 1'b0;
    if (!stall) begin
      ntp = (m_cnt == 1) && m_tk;
      m_xp = ntp && m_ab;
      if (m_cnt == 0) begin
        m_pc = m_pc + 1'b1;
        if (br_valid) begin
          m_cnt = 2; m_tk = ref_cond(br_cond, flags); m_tgt = br_target;
          m_bub = !br_delayed; m_ab = br_abort;
        end
      end else if (m_cnt == 2) begin
        m_cnt = 1;
        if (!m_bub) m_pc = m_pc + 1'b1;
      end else begin
        m_cnt = 0;
        if (m_tk) m_pc = m_tgt;
        else if (!m_bub) m_pc = m_pc + 1'b1;
      end
    end else m_xp = 1'b0;
    m_tp = ntp;
  endtask

  task automatic cyc(input logic s, input logic bv, input logic [4:0] c,
                     input logic [AW-1:0] t, input logic d, input logic a,
                     input logic [7:0] f, input string tag);
    @(negedge clk); #1;
    stall = s; br_valid = bv; br_cond = c; br_target = t;
    br_delayed = d; br_abort = a; flags = f;
    model_push(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 5'd0, '0, 0, 0, flags, tag);
  endtask

  always @(negedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [AW+2:0] e, g;
      string tg;
      e = exp_q.pop_front(); tg = tag_q.pop_front();
      g = {fetch_addr, issue_valid, taken, loop_exit};
      checks++;
      if (g !== e) begin
        failures++;
        $display("FAIL %s got addr=%h v=%b t=%b x=%b exp addr=%h v=%b t=%b x=%b",
                 tg, g[AW+2:3], g[2], g[1], g[0], e[AW+2:3], e[2], e[1], e[0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (fetch_addr !== '0 || taken !== 1'b0 || loop_exit !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset got addr=%h t=%b x=%b exp addr=0 t=0 x=0",
               fetch_addr, taken, loop_exit);
    end
    #1 rst_n = 1'b1;
    model_push("R1 first cycle");
    idle(4, "R2 sequential");
    // R5 delayed taken on zero flag, R3 code 0
    cyc(0, 1, 5'd0, 16'h0100, 1, 0, 8'h01, "R5 delayed taken accept");
    idle(5, "R5 delayed taken slots");
    cyc(0, 1, 5'd0, 16'h0200, 1, 0, 8'h00, "R5 delayed not taken");
    idle(5, "R5 not taken slots");
    // R6 bubble mode, R3 code 1
    cyc(0, 1, 5'd1, 16'h0300, 0, 0, 8'h02, "R6 bubble taken");
    idle(5, "R6 bubble taken slots");
    cyc(0, 1, 5'd1, 16'h0400, 0, 0, 8'h00, "R6 bubble not taken");
    idle(5, "R6 not taken slots");
    // R7 flags change inside window
    cyc(0, 1, 5'd3, 16'h0500, 1, 0, 8'h04, "R7 accept with carry");
    cyc(0, 0, 5'd0, '0, 0, 0, 8'h00, "R7 flags cleared slot1");
    cyc(0, 0, 5'd0, '0, 0, 0, 8'h00, "R7 flags cleared slot2");
    idle(2, "R7 redirect kept");
    cyc(0, 1, 5'd3, 16'h0600, 0, 0, 8'h00, "R7 accept no carry");
    cyc(0, 0, 5'd0, '0, 0, 0, 8'h04, "R7 flags set slot1");
    idle(3, "R7 still not taken");
    // R8 stall inside window
    cyc(0, 1, 5'd9, 16'h0700, 1, 0, 8'h00, "R8 accept always");
    cyc(1, 0, 5'd0, '0, 0, 0, 8'h00, "R8 stall slot");
    cyc(1, 0, 5'd0, '0, 0, 0, 8'h00, "R8 stall slot again");
    idle(2, "R8 resume slots");
    cyc(1, 0, 5'd0, '0, 0, 0, 8'h00, "R8 stall on target");
    idle(2, "R8 after stall");
    cyc(1, 1, 5'd9, 16'h0777, 1, 0, 8'h00, "R8 stalled request dropped");
    idle(2, "R8 no window");
    // R10 requests inside window ignored
    cyc(0, 1, 5'd9, 16'h0800, 0, 0, 8'h00, "R10 accept");
    cyc(0, 1, 5'd9, 16'h0900, 1, 0, 8'h00, "R10 ignored req slot1");
    cyc(0, 1, 5'd9, 16'h0A00, 1, 0, 8'h00, "R10 ignored req slot2");
    idle(3, "R10 target of first");
    // R9 abort with delayed
    cyc(0, 1, 5'd9, 16'h0B00, 1, 1, 8'h00, "R9 delayed abort");
    idle(5, "R9 exit pulse");
    cyc(0, 1, 5'd2, 16'h0C00, 0, 1, 8'h00, "R9 abort not taken");
    idle(4, "R9 no exit");
    // R3 R4 sweep of all codes
    for (int c = 0; c < 32; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] fp;
        fp = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h5A;
        cyc(0, 1, c[4:0], 16'h4000 + 16'(c * 4 + p), p[0], 0, fp, "R3 R4 code sweep");
        idle(3, "R3 R4 code sweep");
      end
    end
    idle(2, "drain");
    @(negedge clk); #8;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule